// File: doc/BRIEF.md
# Group Write Staging and Deferred Commit

This block sits between a bus slave front end and a register file. It lets a controller deliver a whole batch of register writes, possibly spread over many devices on the same bus, as one packet. Inside the packet, commands are separated by repeated STARTs. Writes that target this device are parked in a small staging memory. The live registers see nothing until the STOP that closes the packet.

When that STOP arrives, the staged writes are replayed to the register file in the order they arrived, one per clock, under a busy flag. Writes aimed at other devices, repeated STARTs, and an empty packet leave the staged data and the registers untouched. A fresh START discards any leftovers from an earlier unfinished packet. Writes beyond the staging capacity are dropped and raise a sticky error.

Top module: `group_write_stager`

## Requirements
- R1: After synchronous reset, `busy`, `cm_valid` and `ovf_err` are all 0.
- R2: A write with `wr_valid=1` and `addr_match=1` is staged, and it produces no `cm_valid` pulse before a STOP.
- R3: A `bus_rstart` pulse neither commits nor clears the staged writes. Writes staged before and after it are all committed at the next STOP.
- R4: Suppose STOP is sampled at clock edge E0 and N staged writes (N>0) are held. Then `cm_valid` is 1 in the N cycles following edges E1..EN, carrying the writes in arrival order. `busy` is 1 in the cycles following edges E0..EN and 0 after that.
- R5: A write with `addr_match=0` is not staged and does not disturb the entries already staged.
- R6: At most DEPTH (default 4) writes are staged per packet. Further matched writes are dropped and set `ovf_err`, which stays 1 until reset.
- R7: A `bus_start` pulse (fresh START) discards all staged writes.
- R8: A STOP with no staged writes produces no `cm_valid` pulse and does not raise `busy`.
- R9: While `busy` is 1, writes, STARTs, repeated STARTs and STOPs are ignored.
- R10: After a commit finishes, the staging memory is empty, so a following STOP commits nothing.
- R11: When several indications coincide in one cycle, STOP takes priority over START, START over repeated START, and repeated START over a write. Only the highest-priority one acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Fresh START detected (one-cycle pulse) |
| bus_rstart | input | 1 | Repeated START detected (one-cycle pulse) |
| bus_stop | input | 1 | STOP detected (one-cycle pulse) |
| wr_valid | input | 1 | Decoded register write complete (one-cycle pulse) |
| addr_match | input | 1 | Device address of the current segment matched this device |
| wr_addr | input | AW | Register address of the write |
| wr_data | input | DW | Data of the write |
| cm_valid | output | 1 | Commit strobe to the register file |
| cm_addr | output | AW | Register address being committed |
| cm_data | output | DW | Data being committed |
| busy | output | 1 | Commit sequence in progress |
| ovf_err | output | 1 | Sticky staging overflow flag |

## Verification
Several packet patterns are applied. One interleaves matched and unmatched segments, which shows whether foreign writes leak into the staged set or reorder it. One uses chains of repeated STARTs, which separates a correct design from one that commits or clears at a repeated START. One overfills the buffer, which exposes off-by-one capacity errors and a non-sticky error flag. Aborted packets followed by a fresh START, empty packets, and traffic injected during the commit burst check clearing, the no-commit case and the busy lockout. A second STOP after a commit checks that the buffer was emptied.

// File: rtl/gwc_pkg.sv
package gwc_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_STAGE  = 2'd1,
    EV_CLEAR  = 2'd2,
    EV_COMMIT = 2'd3
  } bus_ev_e;
endpackage

// File: rtl/gwc_evdec.sv
module gwc_evdec
  import gwc_pkg::*;
(
  input  logic    busy,
  input  logic    bus_start,
  input  logic    bus_rstart,
  input  logic    bus_stop,
  input  logic    wr_valid,
  input  logic    addr_match,
  output bus_ev_e ev
);
  // Priority R11: stop > start > repeated start > write; nothing acts while busy (R9)
  always_comb begin
    ev = EV_NONE;
    if (busy)                      ev = EV_NONE;
    else if (bus_stop)             ev = EV_COMMIT;
    else if (bus_start)            ev = EV_CLEAR;
    else if (bus_rstart)           ev = EV_NONE;
    else if (wr_valid && addr_match) ev = EV_STAGE;
  end
endmodule

// File: rtl/gwc_stage_ram.sv
module gwc_stage_ram #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW   = AW + DW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gwc_ctrl.sv
module gwc_ctrl
  import gwc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_ev_e       ev,
  output logic          we,
  output logic [PW-1:0] waddr,
  output logic          re,
  output logic [PW-1:0] raddr,
  output logic          cm_valid,
  output logic          busy,
  output logic          ovf_err
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt;
  logic [PW-1:0] rd;
  logic          drain;
  logic          go;
  logic          last;

  assign go    = (ev == EV_COMMIT) && (cnt != '0);
  assign last  = (CW'(rd) == cnt - CW'(1));
  assign we    = (ev == EV_STAGE) && (cnt < FULL);
  assign waddr = PW'(cnt);
  assign re    = drain;
  assign raddr = rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rd       <= '0;
      drain    <= 1'b0;
      busy     <= 1'b0;
      cm_valid <= 1'b0;
      ovf_err  <= 1'b0;
    end else begin
      cm_valid <= drain;
      busy     <= go | drain;
      if (drain) begin
        if (last) begin
          drain <= 1'b0;
          rd    <= '0;
          cnt   <= '0;
        end else begin
          rd <= rd + PW'(1);
        end
      end
      case (ev)
        EV_COMMIT: if (cnt != '0) drain <= 1'b1;
        EV_CLEAR:  cnt <= '0;
        EV_STAGE:  if (cnt < FULL) cnt <= cnt + CW'(1);
                   else ovf_err <= 1'b1;
        default: ;
      endcase
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst) cnt <= FULL);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst) ovf_err |=> ovf_err);
  p_strobe_busy_r4: assert property (@(posedge clk) disable iff (rst) cm_valid |-> busy);
  p_go_first_r4: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy && !cm_valid));
  p_busy_end_r4: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && !drain) |=> !busy);
  p_locked_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ev == EV_NONE));
endmodule

// File: rtl/group_write_stager.sv
module group_write_stager
  import gwc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW   = AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_start,
  input  logic          bus_rstart,
  input  logic          bus_stop,
  input  logic          wr_valid,
  input  logic          addr_match,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cm_valid,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic          busy,
  output logic          ovf_err
);
  bus_ev_e       ev;
  logic          we, re;
  logic [PW-1:0] waddr, raddr;
  logic [EW-1:0] rdata;

  gwc_evdec i_dec (
    .busy(busy), .bus_start(bus_start), .bus_rstart(bus_rstart),
    .bus_stop(bus_stop), .wr_valid(wr_valid), .addr_match(addr_match), .ev(ev)
  );

  gwc_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .ev(ev), .we(we), .waddr(waddr), .re(re),
    .raddr(raddr), .cm_valid(cm_valid), .busy(busy), .ovf_err(ovf_err)
  );

  gwc_stage_ram #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata({wr_addr, wr_data}),
    .re(re), .raddr(raddr), .rdata(rdata)
  );

  assign cm_addr = rdata[EW-1:DW];
  assign cm_data = rdata[DW-1:0];

  p_rstart_nocommit_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rstart && !bus_stop && !bus_start && !busy) |=> !busy);
  p_empty_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cm_valid && !bus_stop) |=> !cm_valid);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy && !cm_valid && !ovf_err));
endmodule

// File: tb/test_group_write_stager.sv
module test_group_write_stager;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 0, bus_rstart = 0, bus_stop = 0, wr_valid = 0, addr_match = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic cm_valid, busy, ovf_err;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  int vectors = 0;
  int errors  = 0;
  string tag = "R1";

  group_write_stager #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_group_write_stager (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_rstart(bus_rstart),
    .bus_stop(bus_stop), .wr_valid(wr_valid), .addr_match(addr_match),
    .wr_addr(wr_addr), .wr_data(wr_data), .cm_valid(cm_valid),
    .cm_addr(cm_addr), .cm_data(cm_data), .busy(busy), .ovf_err(ovf_err)
  );

  always #4 clk = ~clk;

  // Behavioural reference model
  logic [AW+DW-1:0] stage_q[$];
  logic [AW+DW-1:0] drain_q[$];
  logic m_busy = 0, m_cmv = 0, m_err = 0;
  logic [AW+DW-1:0] m_out = '0;

  always @(posedge clk) begin
    logic issued, go;
    issued = 0; go = 0;
    if (rst) begin
      stage_q.delete(); drain_q.delete();
      m_busy = 0; m_cmv = 0; m_err = 0;
    end else begin
      m_cmv = 0;
      if (drain_q.size() > 0) begin
        m_out = drain_q.pop_front();
        m_cmv = 1; issued = 1;
      end
      if (!m_busy) begin
        if (bus_stop) begin
          if (stage_q.size() > 0) begin
            drain_q = stage_q; stage_q.delete(); go = 1;
          end
        end else if (bus_start) stage_q.delete();
        else if (bus_rstart) ;
        else if (wr_valid && addr_match) begin
          if (stage_q.size() < DEPTH) stage_q.push_back({wr_addr, wr_data});
          else m_err = 1;
        end
      end
      m_busy = issued | go;
    end
    #2;
    vectors++;
    if (cm_valid !== m_cmv || busy !== m_busy || ovf_err !== m_err ||
        (m_cmv && {cm_addr, cm_data} !== m_out)) begin
      errors++;
      $display("FAIL %s: got v=%0b b=%0b e=%0b a=%h d=%h exp v=%0b b=%0b e=%0b a=%h d=%h",
               tag, cm_valid, busy, ovf_err, cm_addr, cm_data,
               m_cmv, m_busy, m_err, m_out[AW+DW-1:DW], m_out[DW-1:0]);
    end
  end

  task automatic cyc(input logic s, input logic rs, input logic p,
                     input logic w, input logic m, input int a, input int d);
    @(negedge clk);
    bus_start = s; bus_rstart = rs; bus_stop = p; wr_valid = w;
    addr_match = m; wr_addr = AW'(a); wr_data = DW'(d);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic m, input int a, input int d);
    cyc(0, 0, 0, 1, m, a, d);
  endtask
  task automatic start();  cyc(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic rstart(); cyc(0, 1, 0, 0, 0, 0, 0); endtask
  task automatic stop();   cyc(0, 0, 1, 0, 0, 0, 0); endtask

  int strobes = 0;
  always @(negedge clk) if (!rst && cm_valid) strobes++;

  task automatic expect_strobes(input int n, input string t);
    vectors++;
    if (strobes != n) begin
      errors++;
      $display("FAIL %s: strobe count got %0d exp %0d", t, strobes, n);
    end
    strobes = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    idle(3);
    @(negedge clk) rst = 0;
    idle(3);
    strobes = 0;
    // R2 / R5: staged, foreign segment skipped, nothing until STOP
    tag = "R2_R5";
    start(); wr(1, 8'h10, 16'h1111); rstart(); wr(0, 8'h55, 16'hDEAD);
    rstart(); wr(1, 8'h20, 16'h2222); idle(4);
    expect_strobes(0, "R2");
    tag = "R4"; stop(); idle(8);
    expect_strobes(2, "R4");
    // R3: repeated START chains
    tag = "R3";
    start(); wr(1, 8'h01, 16'hA001); rstart(); rstart(); wr(1, 8'h02, 16'hA002);
    rstart(); idle(3); expect_strobes(0, "R3");
    stop(); idle(6); expect_strobes(2, "R3");
    // R6: overflow
    tag = "R6";
    start();
    for (int i = 0; i < 6; i++) begin rstart(); wr(1, 8'h30 + i, 16'h3000 + i); end
    stop(); idle(8); expect_strobes(4, "R6");
    // R7: fresh START discards leftovers
    tag = "R7";
    start(); wr(1, 8'h40, 16'h4040); wr(1, 8'h41, 16'h4141);
    start(); wr(1, 8'h42, 16'h4242); stop(); idle(6);
    expect_strobes(1, "R7");
    // R8: empty packet
    tag = "R8";
    start(); wr(0, 8'h50, 16'h5050); stop(); idle(4);
    expect_strobes(0, "R8");
    // R9: events during commit ignored
    tag = "R9";
    start(); wr(1, 8'h60, 16'h6060); wr(1, 8'h61, 16'h6161); wr(1, 8'h62, 16'h6262);
    stop(); wr(1, 8'h63, 16'h6363); start(); stop(); idle(6);
    expect_strobes(3, "R9");
    // R10: buffer empty after commit
    tag = "R10";
    stop(); idle(4); expect_strobes(0, "R10");
    // R11: coincident indications
    tag = "R11";
    start(); wr(1, 8'h70, 16'h7070);
    cyc(0, 1, 0, 1, 1, 8'h71, 16'h7171);   // rstart wins over write
    cyc(1, 0, 1, 1, 1, 8'h72, 16'h7272);   // stop wins
    idle(5); expect_strobes(1, "R11");
    cyc(1, 1, 0, 1, 1, 8'h73, 16'h7373);   // start wins over write
    stop(); idle(4); expect_strobes(0, "R11");
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule